// File: doc/BRIEF.md
# ADC Result Register Bank

This block keeps the latest conversion result of each of sixteen analog channels served by one successive-approximation converter. When the converter finishes a conversion it presents a 12-bit result with a channel index, and the bank stores that result, left-justified, in the 16-bit register for that channel. A chip with two converters places two copies of the block.

The processor side reads through a valid/ready port. Each read returns either the whole 16-bit word, whose four low bits are always zero, or an upper-byte view holding bits 15:8 of the word. The processor has no write path.

A store and a read that aim at the same register in the same short window never overlap. If a store is arriving or in progress, a read of that register is held off by dropping `rd_ready`, and it then returns the new value. If a read is already in progress, a store to that register waits in a one-entry pending slot and is applied as soon as the read ends. Stores to other registers go ahead without delay. The `st_done` pulse marks the cycle in which a result is actually written, for use by later interrupt logic.

Top module: `adc_result_bank`

## Requirements
- R1: After reset every register reads as 16'h0000 in both views.
- R2: A word read (`rd_upper`=0) returns the stored 12-bit result in bits 15:4, and bits 3:0 are zero.
- R3: An upper-byte read (`rd_upper`=1) returns bits 15:8 of the word (result bits 11:4) in `rd_data[7:0]`, and `rd_data[15:8]` is zero.
- R4: A read accepted in cycle t (`rd_valid` and `rd_ready` both high) gives a single-cycle `rd_rvalid` with its data in cycle t+2.
- R5: A store in cycle t to a register that no read has in progress raises `st_done` in cycle t+1. Reads accepted from cycle t+2 onward return the new value. Stores are at least two cycles apart.
- R6: While a store to register k is arriving or in progress, `rd_ready` is low for reads of k. The read is accepted afterwards and returns the new value.
- R7: A store to register k that arrives while a read of k is in progress is deferred. The read returns the old value, `st_done` rises one cycle later than in R5, and later reads return the new value.
- R8: A store to a register other than the one being read proceeds with no delay: `st_done` rises in cycle t+1.
- R9: When a store and a read of the same register arrive in the same cycle and neither access is in progress, the store wins and `rd_ready` is low in that cycle.
- R10: A store changes only the register named by its index. Every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Conversion result available this cycle |
| st_idx | input | 4 | Channel index of the result |
| st_res | input | 12 | Conversion result |
| st_done | output | 1 | Result written into the bank this cycle |
| rd_valid | input | 1 | Read request, held until accepted |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_idx | input | 4 | Register to read |
| rd_upper | input | 1 | 1 selects the upper-byte view, 0 the full word |
| rd_rvalid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |

## Verification
Read data is due two cycles after the cycle in which the request is accepted. The scoreboard therefore pushes each expected value at acceptance and pops it on `rd_rvalid`, so any extra or missing cycle leaves the queue out of step. `st_done` is due one cycle after a store, or two cycles after a store that was deferred. `rd_ready` is checked in the same cycle as the colliding request. All inputs are driven and all outputs sampled on the falling edge, so every expected cycle is counted from rising edges alone.

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_REGS = 16,
  parameter int RES_W    = 12,
  parameter int WORD_W   = 16,
  parameter int BYTE_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int PAD_W   = WORD_W - RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [RES_W-1:0]  st_res,
  output logic              st_done,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_upper,
  output logic              rd_rvalid,
  output logic [WORD_W-1:0] rd_data
);

  logic [RES_W-1:0] bank [NUM_REGS];

  logic             wr_act;
  logic [IDX_W-1:0] wr_idx;
  logic [RES_W-1:0] wr_res;

  logic             rd_act;
  logic [IDX_W-1:0] rd_q_idx;
  logic             rd_q_upper;

  logic             pend_v;
  logic [IDX_W-1:0] pend_idx;
  logic [RES_W-1:0] pend_res;

  logic st_hits_rd, pend_go, st_go, st_defer, rd_fire;
  logic [WORD_W-1:0] word_view;

  assign st_hits_rd = rd_act && (rd_q_idx == st_idx);
  assign pend_go    = pend_v && !(rd_act && (rd_q_idx == pend_idx));
  assign st_go      = st_valid && !st_hits_rd && !pend_go;
  assign st_defer   = st_valid && !st_go;

  assign rd_ready = !(wr_act   && (wr_idx   == rd_idx)) &&
                    !(st_valid && (st_idx   == rd_idx)) &&
                    !(pend_v   && (pend_idx == rd_idx));
  assign rd_fire  = rd_valid && rd_ready;

  assign st_done   = wr_act;
  assign word_view = {bank[rd_q_idx], {PAD_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act <= 1'b0;
      wr_idx <= '0;
      wr_res <= '0;
    end else begin
      wr_act <= pend_go || st_go;
      wr_idx <= pend_go ? pend_idx : st_idx;
      wr_res <= pend_go ? pend_res : st_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_idx <= '0;
      pend_res <= '0;
    end else if (st_defer) begin
      pend_v   <= 1'b1;
      pend_idx <= st_idx;
      pend_res <= st_res;
    end else if (pend_go) begin
      pend_v   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act     <= 1'b0;
      rd_q_idx   <= '0;
      rd_q_upper <= 1'b0;
      rd_rvalid  <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_act     <= rd_fire;
      rd_q_idx   <= rd_idx;
      rd_q_upper <= rd_upper;
      rd_rvalid  <= rd_act;
      if (rd_act)
        rd_data <= rd_q_upper ? {{(WORD_W-BYTE_W){1'b0}}, word_view[WORD_W-1 -: BYTE_W]}
                              : word_view;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[i] <= '0;
      else if (wr_act && (wr_idx == IDX_W'(i)))
        bank[i] <= wr_res;
    end
  end

  // R4
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> ##1 rd_rvalid);

  // R5
  st_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !(rd_act && rd_q_idx == st_idx) |=> st_done);

  // R6
  no_torn_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_act && wr_act && rd_q_idx == wr_idx));

  // R7
  pend_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |=> !pend_v);

  // R2
  low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act && !rd_q_upper |=> rd_data[PAD_W-1:0] == '0);

  // R3
  byte_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act && rd_q_upper |=> rd_data[WORD_W-1:BYTE_W] == '0);

endmodule

// File: tb/adc_result_bank_bench.sv
module adc_result_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [3:0]  st_idx = '0;
  logic [11:0] st_res = '0;
  logic        st_done;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [3:0]  rd_idx = '0;
  logic        rd_upper = 1'b0;
  logic        rd_rvalid;
  logic [15:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_bank u_adc_result_bank (
    .clk, .rst_n, .st_valid, .st_idx, .st_res, .st_done,
    .rd_valid, .rd_ready, .rd_idx, .rd_upper, .rd_rvalid, .rd_data
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected rd_rvalid", rd_data, 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e, t, rd_data, e);
      end
    end
  end

  task automatic do_read(input logic [3:0] idx, input bit upper, input logic [15:0] exp, input string tag);
    rd_valid = 1'b1; rd_idx = idx; rd_upper = upper;
    forever begin
      #1;
      if (rd_ready) break;
      @(negedge clk);
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic do_store(input logic [3:0] idx, input logic [11:0] res);
    st_valid = 1'b1; st_idx = idx; st_res = res;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 16'h0, 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(st_done === 1'b0 && rd_rvalid === 1'b0, "R1 outputs idle", {14'h0, st_done, rd_rvalid}, 16'h0);
    do_read(4'd0, 1'b0, 16'h0000, "R1 reg0 word");
    do_read(4'd15, 1'b1, 16'h0000, "R1 reg15 byte");
    idle(3);

    // R5 store latency, R2 and R3 formatting
    st_valid = 1'b1; st_idx = 4'd3; st_res = 12'hABC;
    @(negedge clk);
    st_valid = 1'b0;
    chk(st_done === 1'b1, "R5 st_done at t+1", {15'h0, st_done}, 16'h1);
    @(negedge clk);
    chk(st_done === 1'b0, "R5 st_done single pulse", {15'h0, st_done}, 16'h0);
    do_read(4'd3, 1'b0, 16'hABC0, "R2 word left-justified");
    do_read(4'd3, 1'b1, 16'h00AB, "R3 upper byte");
    do_store(4'd15, 12'hFFF);
    idle(1);
    do_read(4'd15, 1'b0, 16'hFFF0, "R2 all ones low nibble zero");
    do_read(4'd15, 1'b1, 16'h00FF, "R3 all ones byte");
    idle(3);

    // R4 read latency
    rd_valid = 1'b1; rd_idx = 4'd3; rd_upper = 1'b0;
    #1;
    chk(rd_ready === 1'b1, "R4 ready when idle", {15'h0, rd_ready}, 16'h1);
    exp_q.push_back(16'hABC0); tag_q.push_back("R4 data");
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_rvalid === 1'b0, "R4 no data at t+1", {15'h0, rd_rvalid}, 16'h0);
    @(negedge clk);
    chk(rd_rvalid === 1'b1, "R4 data at t+2", {15'h0, rd_rvalid}, 16'h1);
    idle(3);

    // R9 and R6: same-cycle store and read of reg 5
    st_valid = 1'b1; st_idx = 4'd5; st_res = 12'h123;
    rd_valid = 1'b1; rd_idx = 4'd5; rd_upper = 1'b0;
    #1;
    chk(rd_ready === 1'b0, "R9 store wins same cycle", {15'h0, rd_ready}, 16'h0);
    @(negedge clk);
    st_valid = 1'b0;
    #1;
    chk(rd_ready === 1'b0, "R6 read held during store", {15'h0, rd_ready}, 16'h0);
    chk(st_done === 1'b1, "R6 store proceeds", {15'h0, st_done}, 16'h1);
    @(negedge clk);
    do_read(4'd5, 1'b0, 16'h1230, "R6 stalled read sees new value");
    idle(3);

    // R7 deferred store behind a read in progress
    do_store(4'd7, 12'h111);
    idle(2);
    rd_valid = 1'b1; rd_idx = 4'd7; rd_upper = 1'b0;
    #1;
    chk(rd_ready === 1'b1, "R7 read accepted", {15'h0, rd_ready}, 16'h1);
    exp_q.push_back(16'h1110); tag_q.push_back("R7 read returns old value");
    @(negedge clk);
    rd_valid = 1'b0;
    st_valid = 1'b1; st_idx = 4'd7; st_res = 12'h222;
    @(negedge clk);
    st_valid = 1'b0;
    chk(st_done === 1'b0, "R7 store deferred", {15'h0, st_done}, 16'h0);
    @(negedge clk);
    chk(st_done === 1'b1, "R7 deferred store written", {15'h0, st_done}, 16'h1);
    @(negedge clk);
    do_read(4'd7, 1'b0, 16'h2220, "R7 later read sees new value");
    idle(3);

    // R8 store to another register during a read
    rd_valid = 1'b1; rd_idx = 4'd7; rd_upper = 1'b1;
    #1;
    exp_q.push_back(16'h0022); tag_q.push_back("R8 read unaffected");
    @(negedge clk);
    rd_valid = 1'b0;
    st_valid = 1'b1; st_idx = 4'd8; st_res = 12'h5A5;
    @(negedge clk);
    st_valid = 1'b0;
    chk(st_done === 1'b1, "R8 other register not delayed", {15'h0, st_done}, 16'h1);
    @(negedge clk);
    do_read(4'd8, 1'b0, 16'h5A50, "R8 value stored");
    idle(3);

    // R10 independence
    do_read(4'd3, 1'b0, 16'hABC0, "R10 reg3 kept");
    do_read(4'd9, 1'b0, 16'h0000, "R10 reg9 untouched");
    do_read(4'd4, 1'b1, 16'h0000, "R10 reg4 untouched");
    idle(4);

    chk(exp_q.size() == 0, "R4 all reads returned", 16'(exp_q.size()), 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule